// File: doc/BRIEF.md
# Dual-Mode 8b/10b Character Decoder

This block sits behind the receive deserializer and turns each framed 10-bit line character into a result on a registered output. The upstream logic presents one character on `charIn` and pulses `charStb` for one clock. The `bypassMode` input selects how that character is handled.

In encoded operation the character is split into its 6-bit and 4-bit sub-blocks. Each sub-block is matched against the legal codes for the current running disparity. The result is either a data byte, a control character, or a violation. A violation covers a code that is in no table, a code sent with the wrong disparity, a data character whose x.7 tail has the wrong form, and a violation pattern that the far end inserts on purpose. All of these raise the same single flag, so a downstream handler can treat a deliberate test error and a real line error in the same way.

In bypass operation the 10 raw bits pass to the output register unchanged. This lets an external protocol engine do its own decoding.

Top module: `dual_char_decoder`

## Requirements
- R1: After reset `qOut`, `ctrlFlag` and `violFlag` are all zero and the running disparity is negative, so the negative-disparity form of D0.0 (`1001110100`) decodes as valid data.
- R2: `charIn[9:4]` holds sub-block bits abcdei, with a in bit 9. `charIn[3:0]` holds fghj, with f in bit 3. A valid data character Dx.y in encoded mode yields `qOut[7:0]` = {y, x}, with y = HGF in bits 7:5 and x = EDCBA in bits 4:0. In that case `qOut[9:8]` = 0, `ctrlFlag` = 0 and `violFlag` = 0.
- R3: The valid control characters are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. Each one yields `qOut[7:0]` = {y, x}, `ctrlFlag` = 1 and `violFlag` = 0.
- R4: A code that is neither valid data nor a valid control character at the current disparity yields `violFlag` = 1, `ctrlFlag` = 0 and `qOut` = 0.
- R5: A character whose encoding is legal only for the opposite running disparity is a violation.
- R6: The deliberate violation pattern `1001111000` is flagged on `violFlag` in exactly the same way as any other invalid code.
- R7: After every character in encoded mode, valid or not, the running disparity becomes positive if the code has more than five ones and negative if it has fewer than five ones. With exactly five ones it keeps its value.
- R8: In bypass mode `qOut` equals the received 10 bits, `ctrlFlag` and `violFlag` are 0, and the running disparity is left unchanged.
- R9: The outputs change only on the clock edge where `charStb` is high, and they hold their values on every other cycle.
- R10: A data character Dx.7 takes the alternate tail (`0111` or `1000`) only for x in {17, 18, 20} when the disparity is negative and for x in {11, 13, 14} when it is positive. In every other case it takes the primary tail (`1110` or `0001`). A data character Dx.7 whose tail has the other form is a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| charStb | input | 1 | One-cycle strobe marking a new character on `charIn` |
| bypassMode | input | 1 | 1 = pass raw bits, 0 = decode |
| charIn | input | 10 | Received character, abcdei in bits 9:4 and fghj in bits 3:0 |
| qOut | output | 10 | Decoded byte in bits 7:0, or the raw character in bypass mode |
| ctrlFlag | output | 1 | High when the decoded character is a control character |
| violFlag | output | 1 | High when the received code is invalid |

## Verification
The bench first sends all 256 data bytes and all twelve control characters as a legal, disparity-correct stream, with idle gaps between them. This separates correct sub-block lookup from hold behaviour.

It then sends:
- legal codes in the wrong disparity form;
- x.7 characters with their tails swapped, which distinguishes data violations from the K23.7 alias;
- the deliberate violation pattern;
- a sweep of all 1024 codes, which exercises the disparity update after invalid characters as well as valid ones.

Bypass bursts are followed by legal encoded characters. Any change to the disparity during the burst therefore shows up as a false violation.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int CODE_W = 10;
  localparam int BYTE_W = 8;
  localparam int SIX_W  = 6;
  localparam int FOUR_W = 4;
  localparam int LOW_W  = 5;
  localparam int HIGH_W = 3;
  localparam int LOW_N  = 1 << LOW_W;
  localparam int HIGH_N = 1 << HIGH_W;

  typedef enum logic [1:0] {KIND_DATA, KIND_K28, KIND_KX7} kind_e;

  typedef struct packed {
    logic loadRaw;
    logic loadDec;
  } ldStb_t;

  // 6-bit code for each 5-bit value, as used at negative disparity
  function automatic logic [SIX_W-1:0] base6(input logic [LOW_W-1:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  function automatic logic [SIX_W-1:0] enc6(input logic [LOW_W-1:0] x,
                                            input logic k28, input logic rdPos);
    logic [SIX_W-1:0] b;
    b = k28 ? 6'b001111 : base6(x);
    if (rdPos && (($countones(b) != 3) || (!k28 && x == 5'd7))) return ~b;
    return b;
  endfunction

  function automatic logic [FOUR_W-1:0] base4(input logic [HIGH_W-1:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [FOUR_W-1:0] enc4(input logic [HIGH_W-1:0] y,
                                             input logic [LOW_W-1:0] x,
                                             input kind_e kind, input logic rd6);
    logic alt;
    logic [FOUR_W-1:0] b;
    alt = (y == 3'd7) &&
          ((kind != KIND_DATA) ||
           (!rd6 && (x inside {5'd17, 5'd18, 5'd20})) ||
           (rd6 && (x inside {5'd11, 5'd13, 5'd14})));
    b = alt ? 4'b0111 : base4(y);
    if (kind == KIND_K28 && (y inside {3'd1, 3'd2, 3'd5, 3'd6})) b = ~b;
    if (rd6 && (($countones(b) != 2) || y == 3'd3 || kind == KIND_K28)) return ~b;
    return b;
  endfunction
endpackage

// File: rtl/dcd_ctrl.sv
module dcd_ctrl
  import dcd_pkg::*;
#(
  parameter bit INIT_RD_POS = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charStb,
  input  logic              bypassMode,
  input  logic [CODE_W-1:0] charIn,
  output ldStb_t            ld,
  output logic              rdPos
);
  localparam int HALF = CODE_W / 2;

  logic [3:0] onesCnt;

  always_comb begin
    ld.loadRaw = charStb && bypassMode;
    ld.loadDec = charStb && !bypassMode;
    onesCnt    = 4'($countones(charIn));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPos <= INIT_RD_POS;
    end else if (ld.loadDec) begin
      if (onesCnt > 4'(HALF))      rdPos <= 1'b1;
      else if (onesCnt < 4'(HALF)) rdPos <= 1'b0;
    end
  end

  p_stb_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ld.loadRaw, ld.loadDec}));
  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !charStb |=> $stable(rdPos));
  p_rd_bypass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (charStb && bypassMode) |=> $stable(rdPos));
  p_rd_heavy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ld.loadDec && $countones(charIn) > HALF) |=> rdPos);
  p_rd_light_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ld.loadDec && $countones(charIn) < HALF) |=> !rdPos);
endmodule

// File: rtl/dcd_datapath.sv
module dcd_datapath
  import dcd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ldStb_t            ld,
  input  logic              rdPos,
  input  logic [CODE_W-1:0] charIn,
  output logic [CODE_W-1:0] qOut,
  output logic              ctrlFlag,
  output logic              violFlag
);
  localparam int PAD_W = CODE_W - BYTE_W;

  logic [SIX_W-1:0]  code6;
  logic [FOUR_W-1:0] code4;
  logic [LOW_W-1:0]  xVal;
  logic [HIGH_W-1:0] yVal;
  logic              found6, found4, k28, kx7, rd6, codeOk;
  logic [2:0]        ones6;
  kind_e             kind6;

  always_comb begin
    code6  = charIn[CODE_W-1:FOUR_W];
    code4  = charIn[FOUR_W-1:0];
    found6 = 1'b0;
    xVal   = '0;
    k28    = 1'b0;
    // 6-bit sub-block lookup at the current disparity
    for (int i = 0; i < LOW_N; i++) begin
      if (enc6(LOW_W'(i), 1'b0, rdPos) == code6) begin
        found6 = 1'b1;
        xVal   = LOW_W'(i);
      end
    end
    if (enc6(5'd28, 1'b1, rdPos) == code6) begin
      found6 = 1'b1;
      xVal   = 5'd28;
      k28    = 1'b1;
    end
    // Disparity at the sub-block boundary
    ones6 = 3'($countones(code6));
    if (ones6 > 3'd3)      rd6 = 1'b1;
    else if (ones6 < 3'd3) rd6 = 1'b0;
    else                   rd6 = rdPos;
    kind6  = k28 ? KIND_K28 : KIND_DATA;
    // 4-bit sub-block lookup
    found4 = 1'b0;
    yVal   = '0;
    kx7    = 1'b0;
    for (int j = 0; j < HIGH_N; j++) begin
      if (enc4(HIGH_W'(j), xVal, kind6, rd6) == code4) begin
        found4 = 1'b1;
        yVal   = HIGH_W'(j);
      end
    end
    if (!found4 && !k28 && (xVal inside {5'd23, 5'd27, 5'd29, 5'd30}) &&
        enc4(3'd7, xVal, KIND_KX7, rd6) == code4) begin
      found4 = 1'b1;
      yVal   = 3'd7;
      kx7    = 1'b1;
    end
    codeOk = found6 && found4;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qOut     <= '0;
      ctrlFlag <= 1'b0;
      violFlag <= 1'b0;
    end else if (ld.loadRaw) begin
      qOut     <= charIn;
      ctrlFlag <= 1'b0;
      violFlag <= 1'b0;
    end else if (ld.loadDec) begin
      if (codeOk) begin
        qOut     <= {{PAD_W{1'b0}}, yVal, xVal};
        ctrlFlag <= k28 || kx7;
        violFlag <= 1'b0;
      end else begin
        qOut     <= '0;
        ctrlFlag <= 1'b0;
        violFlag <= 1'b1;
      end
    end
  end

  p_bypass_raw_r8: assert property (@(posedge clk) disable iff (!rstN)
    ld.loadRaw |=> (qOut == $past(charIn) && !ctrlFlag && !violFlag));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ld.loadRaw || ld.loadDec) |=> ($stable(qOut) && $stable(ctrlFlag) && $stable(violFlag)));
  p_viol_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
    violFlag |-> (qOut == '0 && !ctrlFlag));
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ld.loadDec |=> (qOut[CODE_W-1:BYTE_W] == '0));
endmodule

// File: rtl/dual_char_decoder.sv
module dual_char_decoder
  import dcd_pkg::*;
#(
  parameter bit INIT_RD_POS = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charStb,
  input  logic              bypassMode,
  input  logic [CODE_W-1:0] charIn,
  output logic [CODE_W-1:0] qOut,
  output logic              ctrlFlag,
  output logic              violFlag
);
  ldStb_t ld;
  logic   rdPos;

  dcd_ctrl #(.INIT_RD_POS(INIT_RD_POS)) u_ctrl (
    .clk(clk), .rstN(rstN), .charStb(charStb), .bypassMode(bypassMode),
    .charIn(charIn), .ld(ld), .rdPos(rdPos)
  );

  dcd_datapath u_dp (
    .clk(clk), .rstN(rstN), .ld(ld), .rdPos(rdPos), .charIn(charIn),
    .qOut(qOut), .ctrlFlag(ctrlFlag), .violFlag(violFlag)
  );
endmodule

// File: tb/dual_char_decoder_test.sv
`timescale 1ns/1ps
module dual_char_decoder_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       charStb = 1'b0;
  logic       bypassMode = 1'b0;
  logic [9:0] charIn = '0;
  logic [9:0] qOut;
  logic       ctrlFlag, violFlag;

  dual_char_decoder uut (
    .clk(clk), .rstN(rstN), .charStb(charStb), .bypassMode(bypassMode),
    .charIn(charIn), .qOut(qOut), .ctrlFlag(ctrlFlag), .violFlag(violFlag)
  );

  always #2.5 clk = ~clk;

  // Explicit sub-block columns, both disparities
  logic [5:0] sixN [32] = '{6'b100111,6'b011101,6'b101101,6'b110001,6'b110101,6'b101001,6'b011001,6'b111000,
                            6'b111001,6'b100101,6'b010101,6'b110100,6'b001101,6'b101100,6'b011100,6'b010111,
                            6'b011011,6'b100011,6'b010011,6'b110010,6'b001011,6'b101010,6'b011010,6'b111010,
                            6'b110011,6'b100110,6'b010110,6'b110110,6'b001110,6'b101110,6'b011110,6'b101011};
  logic [5:0] sixP [32] = '{6'b011000,6'b100010,6'b010010,6'b110001,6'b001010,6'b101001,6'b011001,6'b000111,
                            6'b000110,6'b100101,6'b010101,6'b110100,6'b001101,6'b101100,6'b011100,6'b101000,
                            6'b100100,6'b100011,6'b010011,6'b110010,6'b001011,6'b101010,6'b011010,6'b000101,
                            6'b001100,6'b100110,6'b010110,6'b001001,6'b001110,6'b010001,6'b100001,6'b010100};
  logic [3:0] fourN [8] = '{4'b1011,4'b1001,4'b0101,4'b1100,4'b1101,4'b1010,4'b0110,4'b1110};
  logic [3:0] fourP [8] = '{4'b0100,4'b1001,4'b0101,4'b0011,4'b0010,4'b1010,4'b0110,4'b0001};
  logic [3:0] kTailN [8] = '{4'b1011,4'b0110,4'b1010,4'b1100,4'b1101,4'b0101,4'b1001,4'b0111};
  logic [3:0] kTailP [8] = '{4'b0100,4'b1001,4'b0101,4'b0011,4'b0010,4'b1010,4'b0110,4'b1000};

  logic [8:0] decMap [int];         // key rd*1024+code -> {isK, byte}
  logic [9:0] encTab [2][2][256];   // [rd][isK][byte]

  logic [9:0] expQ = '0;
  logic       expC = 1'b0, expV = 1'b0, mRd = 1'b0;
  int         checks = 0, errors = 0;
  string      curTag = "R1";
  bit         done = 1'b0;

  function automatic logic rdAfter(input logic [5:0] s, input logic rd);
    int c = $countones(s);
    return (c > 3) ? 1'b1 : (c < 3) ? 1'b0 : rd;
  endfunction

  task automatic addCode(input int rd, input bit k, input logic [7:0] b, input logic [9:0] code);
    encTab[rd][k][b] = code;
    decMap[rd * 1024 + int'(code)] = {k, b};
  endtask

  task automatic buildTables();
    for (int rd = 0; rd < 2; rd++) begin
      for (int b = 0; b < 256; b++) begin
        logic [4:0] x = 5'(b);
        logic [2:0] y = 3'(b >> 5);
        logic [5:0] s = rd ? sixP[x] : sixN[x];
        logic r6 = rdAfter(s, 1'(rd));
        bit alt = (y == 3'd7) && ((!r6 && (x == 17 || x == 18 || x == 20)) ||
                                  (r6 && (x == 11 || x == 13 || x == 14)));
        logic [3:0] t = alt ? (r6 ? 4'b1000 : 4'b0111) : (r6 ? fourP[y] : fourN[y]);
        addCode(rd, 1'b0, 8'(b), {s, t});
      end
      for (int y = 0; y < 8; y++) begin
        logic [5:0] s = rd ? 6'b110000 : 6'b001111;
        addCode(rd, 1'b1, {3'(y), 5'd28}, {s, rd ? kTailN[y] : kTailP[y]});
      end
      foreach (sixN[x]) begin
        if (x == 23 || x == 27 || x == 29 || x == 30) begin
          logic [5:0] s = rd ? sixP[x] : sixN[x];
          logic r6 = rdAfter(s, 1'(rd));
          addCode(rd, 1'b1, {3'd7, 5'(x)}, {s, r6 ? 4'b1000 : 4'b0111});
        end
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (qOut !== expQ || ctrlFlag !== expC || violFlag !== expV) begin
      errors++;
      $display("FAIL %s: q=%h c=%b v=%b expected q=%h c=%b v=%b",
               curTag, qOut, ctrlFlag, violFlag, expQ, expC, expV);
    end
  endtask

  // Apply at a falling edge, model at the rising edge, check at the next falling edge
  task automatic step(input bit stb, input bit byp, input logic [9:0] code);
    charStb = stb; bypassMode = byp; charIn = code;
    @(posedge clk);
    if (stb) begin
      if (byp) begin
        expQ = code; expC = 1'b0; expV = 1'b0;
      end else begin
        int key = int'(mRd) * 1024 + int'(code);
        int n = $countones(code);
        if (decMap.exists(key)) begin
          expQ = {2'b00, decMap[key][7:0]}; expC = decMap[key][8]; expV = 1'b0;
        end else begin
          expQ = '0; expC = 1'b0; expV = 1'b1;
        end
        if (n > 5) mRd = 1'b1; else if (n < 5) mRd = 1'b0;
      end
    end
    @(negedge clk);
    charStb = 1'b0;
    compare();
  endtask

  task automatic sendEnc(input bit k, input logic [7:0] b);
    step(1'b1, 1'b0, encTab[mRd][k][b]);
  endtask

  function automatic logic [3:0] swapTail(input logic [3:0] t);
    case (t)
      4'b0111: return 4'b1110;
      4'b1110: return 4'b0111;
      4'b1000: return 4'b0001;
      4'b0001: return 4'b1000;
      default: return t;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    buildTables();
    repeat (3) @(negedge clk);
    curTag = "R1";
    compare();                                 // R1 reset values
    rstN = 1'b1;
    @(negedge clk);
    step(1'b1, 1'b0, 10'b1001110100);          // R1 negative start disparity
    step(1'b0, 1'b0, 10'b0);

    curTag = "R2";                              // all data bytes, idle gaps (R9)
    for (int b = 0; b < 256; b++) begin
      sendEnc(1'b0, 8'(b));
      if (b % 7 == 3) begin
        curTag = "R9"; step(1'b0, 1'b0, 10'h3FF); step(1'b0, 1'b1, 10'h155); curTag = "R2";
      end
    end

    curTag = "R3";
    for (int r = 0; r < 2; r++) begin
      for (int y = 0; y < 8; y++) sendEnc(1'b1, {3'(y), 5'd28});
      sendEnc(1'b1, 8'hF7); sendEnc(1'b1, 8'hFB); sendEnc(1'b1, 8'hFD); sendEnc(1'b1, 8'hFE);
    end

    curTag = "R10";                             // wrong tail form on x.7 data
    foreach (sixN[x]) begin
      if (x == 11 || x == 13 || x == 14 || x == 17 || x == 18 || x == 20 || x == 23) begin
        logic [9:0] v = encTab[mRd][0][{3'd7, 5'(x)}];
        step(1'b1, 1'b0, {v[9:4], swapTail(v[3:0])});
        sendEnc(1'b0, 8'h05);
        sendEnc(1'b0, {3'd7, 5'(x)});
      end
    end

    curTag = "R5";                              // opposite-disparity forms
    for (int b = 0; b < 16; b++) begin
      step(1'b1, 1'b0, encTab[~mRd][0][8'(b * 13)]);
      sendEnc(1'b0, 8'(b));
    end

    curTag = "R6";
    for (int r = 0; r < 3; r++) begin
      step(1'b1, 1'b0, 10'b1001111000);
      sendEnc(1'b1, 8'hBC);
    end

    curTag = "R4";
    step(1'b1, 1'b0, 10'b0000000000);
    step(1'b1, 1'b0, 10'b1111111111);
    step(1'b1, 1'b0, 10'b1111000000);
    step(1'b1, 1'b0, 10'b0000011111);

    curTag = "R7";                              // every code, disparity follows ones count
    for (int c = 0; c < 1024; c++) step(1'b1, 1'b0, 10'(c));

    curTag = "R8";
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 8; k++) step(1'b1, 1'b1, 10'($urandom));
      step(1'b0, 1'b1, 10'($urandom));
      for (int k = 0; k < 4; k++) sendEnc(1'b0, 8'($urandom));
    end

    curTag = "R9";
    for (int k = 0; k < 40; k++) begin
      if (k % 3 == 0) step(1'b0, k[0], 10'($urandom));
      else sendEnc(1'b0, 8'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule